// File: doc/BRIEF.md
# Up-Counting Timer Channel with Register Interface

This block is one timer/counter channel for a processor's peripheral space. A counter of up to 28 bits advances by one on every tick of a programmable prescaler while the channel is enabled. When the count equals a programmed end value, or steps past its all-ones value, it returns to zero and raises an expiry event. A mode bit decides what happens next. In one-shot mode the channel disables itself. In periodic mode it keeps counting from zero.

Every expiry latches a pending flag. The interrupt line is high while that flag is set and the interrupt enable is on. Software clears the flag by writing a one to its bit. The four 32-bit registers are reached through single-cycle write and read strobes and a two-bit word address. Read data appears on the cycle after the read strobe.

Top module: `tmr_channel`

## Requirements
- R1: After reset, all four registers read as zero and `irq_o` is low.
- R2: Word address 0 holds the end value, 1 the live count, 2 control and 3 interrupt. Bits above the counter width read as zero in the end-value and count registers. Control bit 28 is enable, control bit 24 is mode and control bits [15:0] are the divisor. Interrupt bit 20 is the enable and bit 16 is pending. All other bits read as zero. `rdata` is updated on the clock edge where `rd_en` is sampled high.
- R3: The count increases by exactly one per tick and only while enable is set. Writing 0 to control stops the channel and freezes the count.
- R4: A divisor N of 2 or more gives one tick every N clocks. A divisor of 0 or 1 gives one tick per clock. The prescaler phase restarts from zero each time the channel is enabled.
- R5: With a non-zero end value E, a tick that finds the count equal to E sets the count to 0 and raises an expiry. The period is therefore E+1 ticks.
- R6: A tick at the all-ones count sets the count to 0 and raises an expiry. An end value of 0 turns off matching, so only this wraparound expires.
- R7: In one-shot mode (control bit 24 = 0), an expiry clears the enable bit and the count stays at 0.
- R8: In periodic mode (control bit 24 = 1), the channel keeps counting up after an expiry.
- R9: Pending sets on every expiry, whether or not the interrupt is enabled. A write with bit 16 = 1 clears it, and a write with bit 16 = 0 leaves it unchanged. An expiry in the same cycle as a clear leaves it set.
- R10: `irq_o` is high exactly while both pending and the interrupt enable are set.
- R11: A software write to the count register loads the written value even when a tick falls in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Word address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered |
| irq_o | output | 1 | Level interrupt request |

## Verification
The bench builds the channel with an 8-bit counter and the default 16-bit divisor. With the narrow counter, full wraparound happens within a few hundred clocks. The bench can therefore check the all-ones expiry, the disabled matching at end value 0 and the masking of upper count bits, along with end-value expiry, one-shot halt, divisor spacing and prescaler restart. The cycle-exact cases are a pending clear that collides with an expiry and a count write that collides with a tick.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int BUS_W         = 32;
  localparam int CTRL_EN_BIT   = 28;
  localparam int CTRL_MODE_BIT = 24;
  localparam int IRQ_EN_BIT    = 20;
  localparam int IRQ_PEND_BIT  = 16;

  typedef enum logic [1:0] {
    REG_MARK  = 2'd0,
    REG_COUNT = 2'd1,
    REG_CTRL  = 2'd2,
    REG_IRQ   = 2'd3
  } tmr_reg_e;

  localparam logic MODE_ONESHOT  = 1'b0;
  localparam logic MODE_PERIODIC = 1'b1;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] phase_q, phase_d;
  logic             last;

  // Divisor 0 or 1 means every clock; a phase past the end also ends the period.
  always_comb begin
    last = (div <= DIV_W'(1)) || (phase_q >= div - DIV_W'(1));
    tick = run & last;
    if (!run)      phase_d = '0;
    else if (last) phase_d = '0;
    else           phase_d = phase_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_d;
  end
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
  parameter int CNT_W = 28
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [CNT_W-1:0] marker,
  input  logic             sw_wr,
  input  logic [CNT_W-1:0] sw_val,
  output logic [CNT_W-1:0] cnt,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             hit_mark, hit_wrap;

  always_comb begin
    hit_mark = (marker != '0) && (cnt_q == marker);
    hit_wrap = (cnt_q == {CNT_W{1'b1}});
    expire   = tick & (hit_mark | hit_wrap);
    if (sw_wr)       cnt_d = sw_val;
    else if (expire) cnt_d = '0;
    else if (tick)   cnt_d = cnt_q + CNT_W'(1);
    else             cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/tmr_irq_ctl.sv
module tmr_irq_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic wr,
  input  logic wr_enable,
  input  logic wr_clear,
  output logic pend,
  output logic ien,
  output logic irq
);
  logic pend_q, pend_d, ien_q, ien_d;

  always_comb begin
    ien_d = wr ? wr_enable : ien_q;
    if (set_evt)               pend_d = 1'b1;
    else if (wr && wr_clear)   pend_d = 1'b0;
    else                       pend_d = pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      ien_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      ien_q  <= ien_d;
    end
  end

  assign pend = pend_q;
  assign ien  = ien_q;
  assign irq  = pend_q & ien_q;
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel #(
  parameter int CNT_W = 28,
  parameter int DIV_W = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [1:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        irq_o
);
  import tmr_pkg::*;

  // Reset: asserted asynchronously, released through two flops.
  logic rst_meta_n, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  logic             wr_mark, wr_cnt, wr_ctrl, wr_irq;
  logic [CNT_W-1:0] marker_q, marker_d;
  logic             en_q, en_d, mode_q, mode_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic             tick, expire, pend, ien;
  logic [CNT_W-1:0] cnt;
  logic [BUS_W-1:0] rd_mux, rdata_q, rdata_d;

  always_comb begin
    wr_mark = wr_en && (addr == REG_MARK);
    wr_cnt  = wr_en && (addr == REG_COUNT);
    wr_ctrl = wr_en && (addr == REG_CTRL);
    wr_irq  = wr_en && (addr == REG_IRQ);
  end

  tmr_prescaler #(.DIV_W(DIV_W)) u_presc (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .run  (en_q),
    .div  (div_q),
    .tick (tick)
  );

  tmr_count_core #(.CNT_W(CNT_W)) u_core (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .tick  (tick),
    .marker(marker_q),
    .sw_wr (wr_cnt),
    .sw_val(wdata[CNT_W-1:0]),
    .cnt   (cnt),
    .expire(expire)
  );

  tmr_irq_ctl u_irq (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .set_evt  (expire),
    .wr       (wr_irq),
    .wr_enable(wdata[IRQ_EN_BIT]),
    .wr_clear (wdata[IRQ_PEND_BIT]),
    .pend     (pend),
    .ien      (ien),
    .irq      (irq_o)
  );

  // Control and end-value next state; a software control write beats self-disable.
  always_comb begin
    marker_d = wr_mark ? wdata[CNT_W-1:0] : marker_q;
    mode_d   = wr_ctrl ? wdata[CTRL_MODE_BIT] : mode_q;
    div_d    = wr_ctrl ? wdata[DIV_W-1:0] : div_q;
    if (wr_ctrl)                               en_d = wdata[CTRL_EN_BIT];
    else if (expire && mode_q == MODE_ONESHOT) en_d = 1'b0;
    else                                       en_d = en_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      marker_q <= '0;
      en_q     <= 1'b0;
      mode_q   <= MODE_ONESHOT;
      div_q    <= '0;
    end else begin
      marker_q <= marker_d;
      en_q     <= en_d;
      mode_q   <= mode_d;
      div_q    <= div_d;
    end
  end

  // Read path: field assembly, then a register loaded on the read strobe.
  always_comb begin
    rd_mux = '0;
    unique case (addr)
      REG_MARK:  rd_mux[CNT_W-1:0] = marker_q;
      REG_COUNT: rd_mux[CNT_W-1:0] = cnt;
      REG_CTRL: begin
        rd_mux[CTRL_EN_BIT]   = en_q;
        rd_mux[CTRL_MODE_BIT] = mode_q;
        rd_mux[DIV_W-1:0]     = div_q;
      end
      REG_IRQ: begin
        rd_mux[IRQ_EN_BIT]   = ien;
        rd_mux[IRQ_PEND_BIT] = pend;
      end
      default: rd_mux = '0;
    endcase
    rdata_d = rd_en ? rd_mux : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) rdata_q <= '0;
    else             rdata_q <= rdata_d;
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/tmr_channel_chk.sv
module tmr_channel_chk #(
  parameter int CNT_W = 28
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             mode,
  input logic             tick,
  input logic             expire,
  input logic             cnt_wr,
  input logic             ctrl_wr,
  input logic [CNT_W-1:0] cnt,
  input logic             pend,
  input logic             ien,
  input logic             irq_o
);
  AST_FROZEN_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !cnt_wr) |=> $stable(cnt)); // R3
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !expire && !cnt_wr) |=> (cnt == CNT_W'($past(cnt) + CNT_W'(1)))); // R3
  AST_TICK_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> en); // R4
  AST_EXPIRE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !cnt_wr) |=> (cnt == '0)); // R5
  AST_ONESHOT_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !mode && !ctrl_wr) |=> !en); // R7
  AST_PERIODIC_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && mode && !ctrl_wr) |=> en); // R8
  AST_PEND_SET: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> pend); // R9
  AST_IRQ_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> (ien && pend)); // R10
endmodule

bind tmr_channel tmr_channel_chk #(.CNT_W(CNT_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_sync_n),
  .en     (en_q),
  .mode   (mode_q),
  .tick   (tick),
  .expire (expire),
  .cnt_wr (wr_cnt),
  .ctrl_wr(wr_ctrl),
  .cnt    (cnt),
  .pend   (pend),
  .ien    (ien),
  .irq_o  (irq_o)
);

// File: tb/tmr_channel_tb_top.sv
module tmr_channel_tb_top;
  logic        clk, rst_n, wr_en, rd_en, irq_o;
  logic [1:0]  addr;
  logic [31:0] wdata, rdata;
  int n_tests, n_fail;
  bit done;

  tmr_channel #(.CNT_W(8), .DIV_W(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // Called just after a falling edge; the write lands on the next rising edge.
  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    v = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    for (int i = 0; i < 4; i++) begin
      rd(2'(i), v);
      chk("R1 register reset", v, 32'h0);
    end
    chk("R1 irq_o reset", {31'h0, irq_o}, 32'h0);
  endtask

  task automatic t_map;
    logic [31:0] v;
    wr(2'd0, 32'hABCD_EF12); rd(2'd0, v); chk("R2 end value masked", v, 32'h12);
    wr(2'd1, 32'hFFFF_FF5A); rd(2'd1, v); chk("R2 count masked", v, 32'h5A);
    wr(2'd2, 32'hE1FF_1234); rd(2'd2, v); chk("R2 control fields", v, 32'h0100_1234);
    wr(2'd3, 32'hFFEF_FFFF); rd(2'd3, v); chk("R2 irq fields", v, 32'h0);
    wr(2'd3, 32'h0010_0000); rd(2'd3, v); chk("R2 irq enable bit", v, 32'h0010_0000);
    wr(2'd3, 32'h0); wr(2'd2, 32'h0); wr(2'd0, 32'h0); wr(2'd1, 32'h0);
  endtask

  task automatic t_prescale;
    logic [31:0] v;
    wr(2'd2, 32'h1100_0004); idle(39); wr(2'd2, 32'h0);
    rd(2'd1, v); chk("R4 divisor 4 spacing", v, 32'd10);
    wr(2'd1, 32'h0);
    wr(2'd2, 32'h1100_0004); idle(5); wr(2'd2, 32'h0); idle(3);
    wr(2'd2, 32'h1100_0004); idle(5); wr(2'd2, 32'h0);
    rd(2'd1, v); chk("R4 prescaler restart", v, 32'd2);
    wr(2'd1, 32'h0);
    wr(2'd2, 32'h1100_0000); idle(9); wr(2'd2, 32'h0);
    rd(2'd1, v); chk("R4 divisor 0 each clock", v, 32'd10);
    idle(20); rd(2'd1, v); chk("R3 frozen while off", v, 32'd10);
  endtask

  task automatic t_marker;
    logic [31:0] v;
    wr(2'd0, 32'd5); wr(2'd1, 32'h0);
    wr(2'd2, 32'h1100_0001); idle(13); wr(2'd2, 32'h0);
    rd(2'd1, v); chk("R5 R8 end value period", v, 32'd2);
    rd(2'd3, v); chk("R9 pending without enable", v, 32'h0001_0000);
    chk("R10 irq_o masked", {31'h0, irq_o}, 32'h0);
    wr(2'd3, 32'h0001_0000); rd(2'd3, v); chk("R9 clear by one", v, 32'h0);
  endtask

  task automatic t_oneshot;
    logic [31:0] v;
    wr(2'd3, 32'h0010_0000); wr(2'd0, 32'd3); wr(2'd1, 32'h0);
    wr(2'd2, 32'h1000_0001); idle(20);
    rd(2'd1, v); chk("R7 one-shot count held", v, 32'h0);
    rd(2'd2, v); chk("R7 enable self-cleared", v, 32'h0000_0001);
    chk("R10 irq_o asserted", {31'h0, irq_o}, 32'h1);
    wr(2'd3, 32'h0010_0000); rd(2'd3, v); chk("R9 zero write keeps pending", v, 32'h0011_0000);
    wr(2'd3, 32'h0011_0000); rd(2'd3, v); chk("R9 cleared", v, 32'h0010_0000);
    chk("R10 irq_o dropped", {31'h0, irq_o}, 32'h0);
    wr(2'd3, 32'h0);
  endtask

  task automatic t_wrap;
    logic [31:0] v;
    wr(2'd0, 32'h0); wr(2'd1, 32'hFC);
    wr(2'd2, 32'h1100_0001); idle(5); wr(2'd2, 32'h0);
    rd(2'd1, v); chk("R6 wrap with matching off", v, 32'd2);
    rd(2'd3, v); chk("R6 wrap expiry pending", v, 32'h0001_0000);
    wr(2'd3, 32'h0001_0000);
  endtask

  task automatic t_collide;
    logic [31:0] v;
    wr(2'd0, 32'd3); wr(2'd1, 32'h0);
    wr(2'd2, 32'h1100_0001); idle(3);
    wr(2'd3, 32'h0001_0000); wr(2'd2, 32'h0);
    rd(2'd3, v); chk("R9 set beats clear", v, 32'h0001_0000);
    wr(2'd3, 32'h0001_0000);
    wr(2'd0, 32'h0); wr(2'd1, 32'h0);
    wr(2'd2, 32'h1100_0001); idle(4);
    wr(2'd1, 32'h40); wr(2'd2, 32'h0);
    rd(2'd1, v); chk("R11 write beats tick", v, 32'h41);
  endtask

  initial begin
    n_tests = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    idle(5); rst_n = 1'b1; idle(4);
    t_reset; t_map; t_prescale; t_marker; t_oneshot; t_wrap; t_collide;
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule